// File: doc/BRIEF.md
# I2C SCL Bit-Phase Timer

This block paces the serial clock of an I2C controller acting as bus master in standard, fast and fast-plus operation. A 16-bit rate count sets the length of each clock phase, and a 2-bit speed selector chooses the low/high proportion. Each bit period starts with a low phase, during which the block pulls SCL low. A high phase follows, during which the block releases SCL. Single-cycle strobes tell the bit sequencer when a bit begins, when SDA may be changed, when SDA should be sampled and when the bit is over.

The block reads the SCL line back through `scl_in`. If a slave holds the line low after the block has released it, the high-phase count waits until the line reads high. The data-change point of the next low phase is then postponed by a programmable setup count, measured in clock cycles, and the low phase is stretched if needed so that SCL never rises before that change point. A rate count of zero is handled as one. The rate, speed and setup inputs must be held stable while `run` is high.

Top module: `i2c_scl_timer`

## Requirements
- R1: While `rst_n` is low, and in idle while `run` is low, `scl_drive_low` and all four strobes are 0.
- R2: Speed codes 0 (standard): with effective rate R, the low phase (`scl_drive_low`=1) lasts R cycles, and an unstretched high phase lasts R cycles. `stb_start` is high in the first low cycle and `stb_end` in the last high cycle.
- R3: Speed codes 1 and 2 (fast, fast-plus): the low phase lasts 2R cycles and an unstretched high phase lasts R cycles.
- R4: Speed code 3 (unsupported) produces exactly the standard-mode timing of R2.
- R5: A rate input of 0 gives the same timing as a rate of 1.
- R6: When the preceding high phase was not stretched, or the bit is the first after idle, `stb_change` is high in the first low cycle.
- R7: `stb_sample` is high in the high-phase cycle where floor(R/2) cycles have already been counted with `scl_in` high, counting from 0.
- R8: While SCL is released and `scl_in` reads 0, the high count holds. A high phase with S such cycles lasts S+R cycles.
- R9: After a stretched high phase, `stb_change` fires at low-cycle index D, where D is the setup input. That low phase lasts max(L, D+1) cycles, with L the nominal low length.
- R10: The setup delay applies only to the first low phase after a stretch. A later unstretched bit returns to index 0.
- R11: Bits follow back to back while `run` is high at `stb_end`. With `run` low at `stb_end`, the block goes idle with SCL released. From idle, `stb_start` appears one cycle after `run` is sampled high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run | input | 1 | Request to generate bit periods |
| rate | input | 16 | Phase length count in clock cycles (0 treated as 1) |
| speed | input | 2 | 0 standard, 1 fast, 2 fast-plus, 3 falls back to standard |
| setup | input | 16 | Data-setup delay in cycles applied after a stretch |
| scl_in | input | 1 | Sampled SCL line level |
| scl_drive_low | output | 1 | 1 pulls SCL low, 0 releases it |
| stb_start | output | 1 | First cycle of a bit period |
| stb_sample | output | 1 | SDA sample point |
| stb_change | output | 1 | Point at which SDA may change |
| stb_end | output | 1 | Last cycle of a bit period |

## Verification
On every cycle, the assertions check four things. The high count stays frozen while the line is held low. SCL is never released before the change point of the current low phase. Only one change strobe fires per low phase. Each start strobe follows either idle or a bit end, and a bit end with `run` high leads straight into a new start. Only the bench scenarios can show the exact phase lengths for each speed code and rate, including rate zero. The same goes for where the sample and change strobes fall, how the setup delay stretches a short low phase, and that the delay is dropped again on the bit after the stretched one. The bench gets these from a bus model in which a slave holds SCL low for a chosen number of cycles.

// File: rtl/i2c_scl_timer.sv
module i2c_scl_timer #(
  parameter int RATE_W  = 16,
  parameter int SETUP_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               run,
  input  logic [RATE_W-1:0]  rate,
  input  logic [1:0]         speed,
  input  logic [SETUP_W-1:0] setup,
  input  logic               scl_in,
  output logic               scl_drive_low,
  output logic               stb_start,
  output logic               stb_sample,
  output logic               stb_change,
  output logic               stb_end
);
  localparam int LEN_W = RATE_W + 1;
  localparam int CNT_W = (LEN_W > SETUP_W) ? LEN_W : SETUP_W;

  typedef enum logic [1:0] {ST_IDLE, ST_LOW, ST_HIGH} phase_t;

  phase_t            st;
  logic [CNT_W-1:0]  cnt;
  logic              stretched;

  logic              fast;
  logic [RATE_W-1:0] r_eff;
  logic [CNT_W-1:0]  low_len, high_len, delay, sample_pt;
  logic              low_done, high_done;

  assign fast      = (speed == 2'd1) || (speed == 2'd2);
  assign r_eff     = (rate == '0) ? RATE_W'(1) : rate;
  assign high_len  = CNT_W'(r_eff);
  assign low_len   = fast ? CNT_W'({r_eff, 1'b0}) : CNT_W'(r_eff);
  assign delay     = stretched ? CNT_W'(setup) : '0;
  assign sample_pt = high_len >> 1;

  assign low_done  = (cnt >= low_len - CNT_W'(1)) && (cnt >= delay);
  assign high_done = scl_in && (cnt == high_len - CNT_W'(1));

  assign scl_drive_low = (st == ST_LOW);
  assign stb_start     = (st == ST_LOW) && (cnt == '0);
  assign stb_change    = (st == ST_LOW) && (cnt == delay);
  assign stb_sample    = (st == ST_HIGH) && scl_in && (cnt == sample_pt);
  assign stb_end       = (st == ST_HIGH) && high_done;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      cnt       <= '0;
      stretched <= 1'b0;
    end else begin
      unique case (st)
        ST_IDLE: begin
          cnt       <= '0;
          stretched <= 1'b0;
          if (run) st <= ST_LOW;
        end
        ST_LOW: begin
          if (stb_change) stretched <= 1'b0;
          if (low_done) begin
            st  <= ST_HIGH;
            cnt <= '0;
          end else begin
            cnt <= cnt + CNT_W'(1);
          end
        end
        ST_HIGH: begin
          if (!scl_in) begin
            stretched <= 1'b1;
          end else if (high_done) begin
            cnt <= '0;
            st  <= run ? ST_LOW : ST_IDLE;
          end else begin
            cnt <= cnt + CNT_W'(1);
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  a_r8_hold_while_low: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_HIGH && !scl_in) |=> (st == ST_HIGH) && $stable(cnt));

  a_r9_release_after_change: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(scl_drive_low) |-> ($past(cnt) >= $past(delay)));

  a_r6_single_change: assert property (@(posedge clk) disable iff (!rst_n)
    stb_change |=> !stb_change);

  a_r11_start_origin: assert property (@(posedge clk) disable iff (!rst_n)
    stb_start |-> ($past(stb_end) || $past(st == ST_IDLE)));

  a_r11_back_to_back: assert property (@(posedge clk) disable iff (!rst_n)
    (stb_end && run) |=> stb_start);

  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_IDLE && !run) |=> (st == ST_IDLE) && !scl_drive_low);
endmodule

// File: tb/i2c_scl_timer_bench.sv
`timescale 1ns/1ps
module i2c_scl_timer_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        run = 1'b0;
  logic        hold = 1'b0;
  logic [15:0] rate = 16'd1;
  logic [15:0] setup = 16'd0;
  logic [1:0]  speed = 2'd0;
  logic        scl_in;
  logic        drv, s_start, s_sample, s_change, s_end;
  int          checks = 0;
  int          fails = 0;
  int unsigned seed_init;

  always #2.5 clk = ~clk;
  assign scl_in = ~drv & ~hold;

  i2c_scl_timer u_i2c_scl_timer (
    .clk(clk), .rst_n(rst_n), .run(run), .rate(rate), .speed(speed),
    .setup(setup), .scl_in(scl_in), .scl_drive_low(drv),
    .stb_start(s_start), .stb_sample(s_sample), .stb_change(s_change), .stb_end(s_end)
  );

  task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  function automatic int eff_rate(input int r);
    return (r == 0) ? 1 : r;
  endfunction

  function automatic bit is_fast(input int sp);
    return (sp == 1) || (sp == 2);
  endfunction

  function automatic int exp_low(input int r, input int sp, input int d);
    int l;
    l = is_fast(sp) ? 2 * eff_rate(r) : eff_rate(r);
    return (l > d + 1) ? l : d + 1;
  endfunction

  function automatic string low_tag(input int r, input int sp, input int d);
    if (d > 0) return "R9";
    if (r == 0) return "R5";
    if (sp == 3) return "R4";
    return is_fast(sp) ? "R3" : "R2";
  endfunction

  task automatic step();
    @(negedge clk);
    #1;
  endtask

  task automatic observe_bit(input int s, input bit last, input int d, input string ctag);
    int lowc, chg, hi, samp, endi, guard, h;
    h = eff_rate(int'(rate));
    chk(s_start === 1'b1, "R2", "start strobe in first low cycle", int'(s_start), 1);
    if (last) run = 1'b0;
    hold = (s > 0);
    lowc = 0; chg = -1; guard = 0; hi = 0;
    while (drv && guard < 100000) begin
      if (s_change) chg = lowc;
      lowc++; guard++;
      @(negedge clk);
      if (!drv) hold = (0 < s);
      #1;
    end
    samp = -1; endi = -1;
    while (endi < 0 && guard < 100000) begin
      if (s_sample) samp = hi;
      if (s_end) endi = hi;
      else begin
        hi++; guard++;
        @(negedge clk);
        hold = (hi < s);
        #1;
      end
    end
    hold = 1'b0;
    chk(lowc == exp_low(int'(rate), int'(speed), d), low_tag(int'(rate), int'(speed), d),
        "low phase length", lowc, exp_low(int'(rate), int'(speed), d));
    chk(chg == d, ctag, "change strobe index", chg, d);
    chk(endi + 1 == s + h, (s > 0) ? "R8" : ((int'(rate) == 0) ? "R5" : "R2"),
        "high phase length", endi + 1, s + h);
    chk(samp == s + (h >> 1), "R7", "sample strobe index", samp, s + (h >> 1));
  endtask

  task automatic session(input int r, input int sp, input int su, input int nbits, input int mode);
    bit prev_st, pp_st;
    int s, d;
    string ctag;
    rate = 16'(r); speed = 2'(sp); setup = 16'(su);
    step();
    chk(!drv && !s_start && !s_change, "R1", "idle before run", int'(drv), 0);
    run = 1'b1;
    step();
    prev_st = 1'b0; pp_st = 1'b0;
    for (int b = 0; b < nbits; b++) begin
      if (mode == 1) s = ($urandom % 3 == 0) ? 1 + int'($urandom % 4) : 0;
      else if (mode == 2) s = (b == 0) ? 3 : 0;
      else s = 0;
      d = prev_st ? su : 0;
      ctag = prev_st ? "R9" : (pp_st ? "R10" : "R6");
      observe_bit(s, b == nbits - 1, d, ctag);
      step();
      if (b != nbits - 1)
        chk(s_start === 1'b1, "R11", "back-to-back start", int'(s_start), 1);
      pp_st = prev_st;
      prev_st = (s > 0);
    end
    chk(!drv && !s_start, "R11", "idle after run dropped", int'(drv), 0);
    step();
    chk(!drv && !s_start && !s_sample && !s_change && !s_end, "R1", "stays idle",
        int'(drv | s_start | s_sample | s_change | s_end), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL R11 watchdog actual=timeout expected=completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    seed_init = $urandom(32'd4242);
    run = 1'b1;
    repeat (3) step();
    chk(!drv && !s_start && !s_sample && !s_change && !s_end, "R1", "outputs in reset",
        int'(drv | s_start | s_sample | s_change | s_end), 0);
    run = 1'b0;
    rst_n = 1'b1;
    step();
    chk(!drv && !s_start, "R1", "idle after reset", int'(drv), 0);

    session(3, 0, 5, 3, 0);
    session(3, 1, 5, 3, 0);
    session(4, 2, 9, 3, 2);
    session(2, 0, 1, 3, 2);
    session(5, 3, 4, 5, 1);
    session(5, 3, 6, 3, 2);
    session(0, 0, 2, 3, 2);
    session(0, 1, 0, 3, 1);
    session(2, 0, 0, 3, 2);
    session(40, 1, 7, 2, 2);
    for (int k = 0; k < 20; k++)
      session(int'($urandom % 13), int'($urandom % 4), int'($urandom % 21),
              4 + int'($urandom % 5), 1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule